// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This block drives the byte-by-byte burning of a one-time-programmable memory array. A command is sampled on a one-cycle `start` strobe. The operation is decoded from four inputs: a flag that says the programming supply is at its high level, a register/memory select, a 16-bit mode address and a read/write line. The block can burn the whole array, compare it against an image, stream it out serially, or lock it against later reads. Any other combination is rejected.

A burn works through the addresses in turn. For each one the block raises a pulse-enable for a fixed number of system clocks, reads the byte back and compares it against the image. If the byte does not match, it pulses again, up to a set number of attempts. When every byte has matched, the block drops its request for the high supply and reads the whole array once more. Any difference in that pass marks the device failed; if there is none, the device passes.

The array itself sits outside the block. It has a synchronous read port with one cycle of latency. It takes its write data from an image source, and the block looks that source up by the array address.

Top module: `otp_burn_seq`

## Requirements
- R1: On `start`, the inputs are decoded as follows. Burn: `hv_on`=1, `reg_sel`=0, `mode_addr`=16'h0000, `rd_wr`=0. Verify: `hv_on`=1, `reg_sel`=0, `mode_addr`=16'h0000, `rd_wr`=1. Serial read: `hv_on`=0, `reg_sel`=0, `mode_addr`=16'h0000, `rd_wr`=1. Lock: `hv_on`=1, `reg_sel`=1, `mode_addr`=16'h0E3F, `rd_wr`=0. Any other combination sets `fail` in the next cycle, with no pulse, no `hv_req` and no `busy`.
- R2: Each attempt holds `arr_pulse` high for exactly PULSE_CYC consecutive cycles, and `hv_req` is high throughout.
- R3: After each pulse there is one read-latency cycle and then one compare cycle. A match moves the burn to the next address, starting at 0 and ending at DEPTH-1. A mismatch starts another pulse at the same address.
- R4: If a byte still mismatches after MAX_TRIES pulses, the run ends in the cycle after its last compare, with `fail`=1, `busy`=0 and `hv_req`=0.
- R5: After the last address matches, `hv_req` falls and every byte is compared again, taking two cycles per byte from address 0. The first mismatch ends the run with `fail`. Otherwise `pass` is set after the last byte.
- R6: The verify operation runs only the whole-array compare pass of R5, with no pulses and with `hv_req` low.
- R7: The serial read loads each byte from address 0 upward and shifts it out on `sdat_out`, most significant bit first. Each rising `sclk` edge advances one bit. `sdat_oe` is high while bits are presented, and `pass` is set after the last bit of the last byte.
- R8: The lock operation sets `pass` in the next cycle without `busy`. From then until reset, every serial read returns 8'hFF for each byte.
- R9: `pass` and `fail` are cleared by each `start` and otherwise hold their value. `busy` is high for the whole of a burn, verify or read.
- R10: After reset, `busy`, `pass`, `fail`, `arr_pulse`, `hv_req` and `sdat_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command strobe |
| hv_on | input | 1 | Programming supply is at its high level |
| reg_sel | input | 1 | Register/memory select |
| mode_addr | input | 16 | Address used for operation decode |
| rd_wr | input | 1 | 1 = read/verify, 0 = write |
| sclk | input | 1 | Serial clock, asynchronous input |
| sdat_out | output | 1 | Serial data out |
| sdat_oe | output | 1 | Serial data output enable |
| arr_addr | output | AW | Array and image address |
| arr_wdata | output | 8 | Write data to the array (image byte) |
| arr_pulse | output | 1 | Programming pulse enable |
| arr_rdata | input | 8 | Array read data, one cycle after `arr_addr` |
| img_data | input | 8 | Image byte for `arr_addr` |
| hv_req | output | 1 | Request for the high programming supply |
| busy | output | 1 | Operation in progress |
| pass | output | 1 | Sticky success flag |
| fail | output | 1 | Sticky failure flag |

## Verification
The effects of a command appear at the first falling edge after the edge that samples `start`. At that point `arr_pulse` is already high for a burn, and `fail` or `pass` is already set for a rejected command or a lock. Each attempt therefore takes PULSE_CYC+2 cycles and each compare-pass byte takes two. `pass` or `fail` changes on the falling edge after the final compare. A reference model in the bench walks this schedule at every falling edge and checks `busy`, `hv_req`, `arr_pulse` and `arr_addr` against it. A serial bit moves about three clocks after a rising `sclk`, so the bench holds each `sclk` level for six clocks and samples `sdat_out` only just before raising `sclk`.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    OP_BAD, OP_READ, OP_BURN, OP_VERIFY, OP_LOCK
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PULSE, S_VWAIT, S_VCHK, S_CWAIT, S_CCHK,
    S_RWAIT, S_RLOAD, S_RSHIFT
  } state_e;

  localparam logic [15:0] LOCK_MODE_ADDR = 16'h0E3F;
  localparam logic [15:0] BASE_MODE_ADDR = 16'h0000;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic        hv_on,
  input  logic        reg_sel,
  input  logic [15:0] mode_addr,
  input  logic        rd_wr,
  output op_e         op
);
  always_comb begin
    op = OP_BAD;
    if (!reg_sel && mode_addr == BASE_MODE_ADDR) begin
      if (hv_on)
        op = rd_wr ? OP_VERIFY : OP_BURN;
      else if (rd_wr)
        op = OP_READ;
    end else if (reg_sel && hv_on && !rd_wr && mode_addr == LOCK_MODE_ADDR) begin
      op = OP_LOCK;
    end
  end
endmodule

// File: rtl/otp_sclk_sync.sv
module otp_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic rise
);
  logic [STAGES:0] sh;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) sh[0] <= rst ? 1'b0 : sclk;
      end else begin : g_rest
        always_ff @(posedge clk) sh[g] <= rst ? 1'b0 : sh[g-1];
      end
    end
  endgenerate

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int DEPTH     = 16384,
  parameter int PULSE_CYC = 12000,
  parameter int MAX_TRIES = 10,
  parameter int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  op_e           op,
  input  logic          sclk_rise,
  input  logic [7:0]    arr_rdata,
  input  logic [7:0]    img_data,
  output logic [AW-1:0] arr_addr,
  output logic          arr_pulse,
  output logic          hv_req,
  output logic          busy,
  output logic          pass,
  output logic          fail,
  output logic          sdat_out,
  output logic          sdat_oe
);
  localparam int PCW = $clog2(PULSE_CYC + 1);
  localparam int TW  = $clog2(MAX_TRIES + 1);
  localparam logic [AW-1:0]  LAST   = AW'(DEPTH - 1);
  localparam logic [PCW-1:0] P_LAST = PCW'(PULSE_CYC - 1);
  localparam logic [TW-1:0]  T_MAX  = TW'(MAX_TRIES);

  state_e         state;
  logic [PCW-1:0] pcnt;
  logic [TW-1:0]  tries;
  logic [2:0]     bitcnt;
  logic [7:0]     sreg;
  logic           locked;
  logic           last;
  logic           match;

  assign last     = (arr_addr == LAST);
  assign match    = (arr_rdata == img_data);
  assign sdat_out = sdat_oe & sreg[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      arr_addr  <= '0;
      arr_pulse <= 1'b0;
      hv_req    <= 1'b0;
      busy      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      sdat_oe   <= 1'b0;
      pcnt      <= '0;
      tries     <= '0;
      bitcnt    <= '0;
      sreg      <= '0;
      locked    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          pass     <= 1'b0;
          fail     <= 1'b0;
          arr_addr <= '0;
          pcnt     <= '0;
          tries    <= '0;
          unique case (op)
            OP_BURN: begin
              busy <= 1'b1; hv_req <= 1'b1; arr_pulse <= 1'b1; state <= S_PULSE;
            end
            OP_VERIFY: begin busy <= 1'b1; state <= S_CWAIT; end
            OP_READ:   begin busy <= 1'b1; state <= S_RWAIT; end
            OP_LOCK:   begin locked <= 1'b1; pass <= 1'b1; end
            default:   fail <= 1'b1;
          endcase
        end
        S_PULSE: begin
          if (pcnt == P_LAST) begin
            arr_pulse <= 1'b0;
            tries     <= tries + 1'b1;
            state     <= S_VWAIT;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_VWAIT: state <= S_VCHK;
        S_VCHK: begin
          pcnt <= '0;
          if (match) begin
            if (last) begin
              hv_req   <= 1'b0;
              arr_addr <= '0;
              state    <= S_CWAIT;
            end else begin
              arr_addr  <= arr_addr + 1'b1;
              tries     <= '0;
              arr_pulse <= 1'b1;
              state     <= S_PULSE;
            end
          end else if (tries == T_MAX) begin
            fail   <= 1'b1;
            busy   <= 1'b0;
            hv_req <= 1'b0;
            state  <= S_IDLE;
          end else begin
            arr_pulse <= 1'b1;
            state     <= S_PULSE;
          end
        end
        S_CWAIT: state <= S_CCHK;
        S_CCHK: begin
          if (!match) begin
            fail <= 1'b1; busy <= 1'b0; state <= S_IDLE;
          end else if (last) begin
            pass <= 1'b1; busy <= 1'b0; state <= S_IDLE;
          end else begin
            arr_addr <= arr_addr + 1'b1;
            state    <= S_CWAIT;
          end
        end
        S_RWAIT: state <= S_RLOAD;
        S_RLOAD: begin
          sreg    <= locked ? 8'hFF : arr_rdata;
          bitcnt  <= '0;
          sdat_oe <= 1'b1;
          state   <= S_RSHIFT;
        end
        S_RSHIFT: if (sclk_rise) begin
          sreg   <= {sreg[6:0], 1'b0};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) begin
            if (last) begin
              sdat_oe <= 1'b0; busy <= 1'b0; pass <= 1'b1; state <= S_IDLE;
            end else begin
              arr_addr <= arr_addr + 1'b1;
              state    <= S_RWAIT;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_pulse_hv_R2: assert property (@(posedge clk) disable iff (rst)
    arr_pulse |-> hv_req);
  assert_pulse_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(arr_pulse) |-> $past(pcnt) == P_LAST);
  assert_pulse_busy_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(arr_pulse) |-> busy);
  assert_tries_cap_R4: assert property (@(posedge clk) disable iff (rst)
    tries <= T_MAX);
  assert_read_low_supply_R7: assert property (@(posedge clk) disable iff (rst)
    sdat_oe |-> !hv_req);
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));
  assert_busy_ends_flagged_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (pass || fail));
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_pkg::*;
#(
  parameter int DEPTH       = 16384,
  parameter int PULSE_CYC   = 12000,
  parameter int MAX_TRIES   = 10,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          hv_on,
  input  logic          reg_sel,
  input  logic [15:0]   mode_addr,
  input  logic          rd_wr,
  input  logic          sclk,
  output logic          sdat_out,
  output logic          sdat_oe,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_wdata,
  output logic          arr_pulse,
  input  logic [7:0]    arr_rdata,
  input  logic [7:0]    img_data,
  output logic          hv_req,
  output logic          busy,
  output logic          pass,
  output logic          fail
);
  op_e  op;
  logic sclk_rise;

  assign arr_wdata = img_data;

  otp_mode_dec u_dec (
    .hv_on(hv_on), .reg_sel(reg_sel), .mode_addr(mode_addr), .rd_wr(rd_wr), .op(op)
  );

  otp_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .rise(sclk_rise)
  );

  otp_seq #(.DEPTH(DEPTH), .PULSE_CYC(PULSE_CYC), .MAX_TRIES(MAX_TRIES), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .sclk_rise(sclk_rise),
    .arr_rdata(arr_rdata), .img_data(img_data), .arr_addr(arr_addr),
    .arr_pulse(arr_pulse), .hv_req(hv_req), .busy(busy), .pass(pass),
    .fail(fail), .sdat_out(sdat_out), .sdat_oe(sdat_oe)
  );
endmodule

// File: tb/sim_otp_burn_seq.sv
`timescale 1ns/1ps
module sim_otp_burn_seq;
  localparam int D  = 8;
  localparam int P  = 5;
  localparam int MT = 10;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, hv_on = 1'b0, reg_sel = 1'b0, rd_wr = 1'b0, sclk = 1'b0;
  logic [15:0] mode_addr = 16'h0;
  logic sdat_out, sdat_oe, arr_pulse, hv_req, busy, pass, fail;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata, arr_rdata, img_data;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int bad_addr = -1, drift_addr = -1, poke_addr = -1;
  bit wipe = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] img(int a);
    return 8'(a * 37 + 11);
  endfunction
  function automatic int need(int a);
    return (a == bad_addr) ? 99 : 1 + a % 3;
  endfunction

  assign img_data = img(int'(arr_addr));

  // behavioural array: a byte takes its image value after need() full pulses
  logic [7:0] mem [D];
  int pc [D];
  logic hv_prev = 1'b0;
  always @(posedge clk) begin
    if (wipe) begin
      for (int i = 0; i < D; i++) begin mem[i] = 8'hFF; pc[i] = 0; end
    end else begin
      if (poke_addr >= 0) mem[poke_addr] = mem[poke_addr] ^ 8'h01;
      if (hv_prev && !hv_req && drift_addr >= 0) mem[drift_addr] = mem[drift_addr] ^ 8'h10;
      if (arr_pulse) begin
        pc[arr_addr] = pc[arr_addr] + 1;
        if (pc[arr_addr] == P * need(int'(arr_addr))) mem[arr_addr] = arr_wdata;
      end
    end
    hv_prev = hv_req;
    arr_rdata <= mem[arr_addr];
  end

  otp_burn_seq #(.DEPTH(D), .PULSE_CYC(P), .MAX_TRIES(MT)) u0 (
    .clk(clk), .rst(rst), .start(start), .hv_on(hv_on), .reg_sel(reg_sel),
    .mode_addr(mode_addr), .rd_wr(rd_wr), .sclk(sclk), .sdat_out(sdat_out),
    .sdat_oe(sdat_oe), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_pulse(arr_pulse), .arr_rdata(arr_rdata), .img_data(img_data),
    .hv_req(hv_req), .busy(busy), .pass(pass), .fail(fail)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one reference-model cycle: compare busy/hv/pulse/addr at this falling edge
  task automatic cyc(string req, bit eb, bit ehv, bit ep, int ea);
    @(negedge clk);
    start = 1'b0;
    chk(busy == eb, {req, " busy"}, busy, eb);
    chk(hv_req == ehv, {req, " hv_req"}, hv_req, ehv);
    chk(arr_pulse == ep, {req, " arr_pulse"}, arr_pulse, ep);
    if (eb) chk(int'(arr_addr) == ea, {req, " arr_addr"}, arr_addr, ea);
  endtask

  task automatic issue(bit hv, bit rs, logic [15:0] ma, bit rw);
    @(negedge clk);
    hv_on = hv; reg_sel = rs; mode_addr = ma; rd_wr = rw; start = 1'b1;
  endtask

  task automatic fresh();
    @(negedge clk); wipe = 1'b1;
    @(negedge clk); wipe = 1'b0;
  endtask

  task automatic exp_compare(int fail_at);
    for (int a = 0; a < D; a++) begin
      cyc("R5 compare", 1, 0, 0, a);
      cyc("R5 compare", 1, 0, 0, a);
      if (a == fail_at) begin
        @(negedge clk);
        chk(fail == 1 && pass == 0 && busy == 0, "R5 mismatch fails", {busy, pass, fail}, 3'b001);
        return;
      end
    end
    @(negedge clk);
    chk(pass == 1 && fail == 0 && busy == 0, "R5 compare passes", {busy, pass, fail}, 3'b010);
  endtask

  task automatic exp_burn(int fail_at);
    for (int a = 0; a < D; a++) begin
      int n = need(a) > MT ? MT : need(a);
      for (int t = 0; t < n; t++) begin
        for (int k = 0; k < P; k++) cyc("R2 pulse", 1, 1, 1, a);
        cyc("R3 verify wait", 1, 1, 0, a);
        cyc("R3 verify cmp", 1, 1, 0, a);
      end
      if (a == bad_addr) begin
        @(negedge clk);
        chk(fail == 1 && busy == 0 && hv_req == 0 && pass == 0, "R4 retry limit",
            {busy, hv_req, pass, fail}, 4'b0001);
        return;
      end
    end
    exp_compare(fail_at);
  endtask

  task automatic exp_read(bit locked);
    repeat (3) @(negedge clk);
    start = 1'b0;
    for (int a = 0; a < D; a++) begin
      logic [7:0] e = locked ? 8'hFF : img(a);
      for (int b = 7; b >= 0; b--) begin
        chk(sdat_oe == 1, "R7 oe", sdat_oe, 1);
        chk(sdat_out == e[b], locked ? "R8 locked read" : "R7 serial bit", sdat_out, e[b]);
        sclk = 1'b1; repeat (6) @(negedge clk);
        sclk = 1'b0; repeat (6) @(negedge clk);
      end
    end
    chk(pass == 1 && busy == 0 && sdat_oe == 0, "R7 read end", {busy, pass, sdat_oe}, 3'b010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, pass, fail, arr_pulse, hv_req, sdat_oe} == 6'b0, "R10 reset state",
        {busy, pass, fail, arr_pulse, hv_req, sdat_oe}, 0);

    // R1: write with normal supply is rejected
    issue(0, 0, 16'h0000, 0);
    cyc("R1 bad op", 0, 0, 0, 0);
    chk(fail == 1, "R1 write at normal supply", fail, 1);
    // R1: wrong mode address rejected
    issue(1, 0, 16'h0001, 0);
    cyc("R1 bad addr", 0, 0, 0, 0);
    chk(fail == 1 && pass == 0, "R1 wrong address", fail, 1);

    // good burn
    fresh();
    issue(1, 0, 16'h0000, 0);
    exp_burn(-1);
    repeat (10) @(negedge clk);
    chk(pass == 1 && fail == 0, "R9 pass sticky", pass, 1);

    // serial read of burned array
    issue(0, 0, 16'h0000, 1);
    @(negedge clk);
    chk(busy == 1 && pass == 0, "R9 start clears pass", {busy, pass}, 2'b10);
    exp_read(0);

    // verify passes, then verify with a corrupted byte
    issue(1, 0, 16'h0000, 1);
    exp_compare(-1);
    @(negedge clk); poke_addr = 5;
    @(negedge clk); poke_addr = -1;
    issue(1, 0, 16'h0000, 1);
    exp_compare(5);
    chk(hv_req == 0, "R6 verify no supply request", hv_req, 0);

    // burn with drift discovered only in the final compare
    fresh();
    drift_addr = 3;
    issue(1, 0, 16'h0000, 0);
    exp_burn(3);
    drift_addr = -1;

    // burn with a dead byte at address 2
    fresh();
    bad_addr = 2;
    issue(1, 0, 16'h0000, 0);
    exp_burn(-1);
    bad_addr = -1;

    // lock, then read returns all ones
    fresh();
    issue(1, 0, 16'h0000, 0);
    exp_burn(-1);
    issue(1, 1, 16'h0E3F, 0);
    @(negedge clk); start = 1'b0;
    chk(pass == 1 && busy == 0 && fail == 0, "R8 lock sets pass", {busy, pass, fail}, 3'b010);
    issue(0, 0, 16'h0000, 1);
    exp_read(1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule